// File: doc/BRIEF.md
# Timer Interrupt Vector and Overrun Logic

This block sits beside a capture/compare timer and collects the timer's five event strobes: two compare matches, two capture events and one counter overflow/underflow. Each strobe latches a pending flag. The block combines these flags into one registered interrupt request and an 8-bit vector. A per-source enable mask and a global enable gate the request.

The vector has two parts. Its upper five bits come from a base that software writes. Its lower three bits are a code that the hardware fixes for each group of sources. Overflow/underflow uses 000 and wins over the others. Capture uses 100. Compare uses 110 and loses to both. The block also watches the two sources that can feed a block-transfer engine, compare 0 and capture 0. When a new event arrives on one of them while its previous flag is still pending, the block raises a sticky overrun flag for that source.

Software clears pending flags and overrun flags with one-cycle write-one-to-clear strobes. The processor-side interrupt controller that consumes the request and the vector is not part of this block.

Top module: `tmr_irq_vec`

## Requirements
- R1: A one-cycle strobe on `evt_i[i]` sets `pend_o[i]` on the next clock edge. Bit 0 is compare 0, bit 1 is compare 1, bit 2 is capture 0, bit 3 is capture 1 and bit 4 is overflow/underflow.
- R2: A strobe on `pend_clr_i[i]` clears `pend_o[i]` on the next edge. If `evt_i[i]` is high in the same cycle, the flag stays set.
- R3: `irq_o` is registered. It is high one cycle after a cycle in which `glb_en_i` is high and at least one source has both its `pend_o` bit and its `src_en_i` bit high.
- R4: When the request is computed active, `vec_o[7:3]` loads `vec_base_i` from that same cycle.
- R5: `vec_o[2:0]` holds the group code. Compare (bits 0 and 1) gives 3'b110. Capture (bits 2 and 3) gives 3'b100. Overflow/underflow (bit 4) gives 3'b000.
- R6: When more than one group is enabled and pending, the group with the numerically lowest code is presented: overflow first, then capture, then compare.
- R7: A source whose `src_en_i` bit is 0 affects neither `irq_o` nor the choice of group code. Its pending flag still sets.
- R8: `ovr_o[0]` (compare 0) or `ovr_o[1]` (capture 0) sets on the next edge when that source's event arrives while its pending flag is already set and no clear of that flag is strobed in the same cycle. Compare 1, capture 1 and overflow never produce an overrun.
- R9: Overrun flags are sticky. Only `ovr_clr_i[k]` clears `ovr_o[k]`. A new overrun in the same cycle as that clear leaves the flag set.
- R10: While the request is inactive, `vec_o` holds its last loaded value.
- R11: After a synchronous active-low reset, `pend_o`, `ovr_o`, `irq_o` and `vec_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 5 | One-cycle event strobes, one per source |
| src_en_i | input | 5 | Per-source interrupt enable, 1 = enabled |
| glb_en_i | input | 1 | Global interrupt enable |
| vec_base_i | input | 5 | Software-written upper vector bits |
| pend_clr_i | input | 5 | Write-one-to-clear strobes for the pending flags |
| ovr_clr_i | input | 2 | Write-one-to-clear strobes for the overrun flags |
| pend_o | output | 5 | Pending flags |
| irq_o | output | 1 | Registered interrupt request |
| vec_o | output | 8 | Interrupt vector: base and group code |
| ovr_o | output | 2 | Sticky overrun flags: bit 0 is compare 0, bit 1 is capture 0 |

## Verification
The embedded assertions check every cycle that an event always lands in its pending flag, that an overrun flag rises only after a real overrun and stays set until its own clear, and that the request follows the global enable. They also check that the vector code is always one of the three legal values and that overflow wins whenever it was enabled and pending. Only the bench's scenarios can show the full ordering among the three groups as flags are cleared one by one. The same holds for a same-cycle race between an event and a clear, for a masked source that is pending but never presented, and for a vector that keeps its value while the global enable is off.

// File: rtl/tmr_irq_pkg.sv
// Package: source indices, group codes and widths shared by the timer
// interrupt logic. Assumes five sources in the fixed order below.
package tmr_irq_pkg;
    localparam int NSRC     = 5;
    localparam int SRC_CMP0 = 0;
    localparam int SRC_CMP1 = 1;
    localparam int SRC_CAP0 = 2;
    localparam int SRC_CAP1 = 3;
    localparam int SRC_OVF  = 4;

    localparam int NOVR     = 2;
    localparam int OVR_CMP0 = 0;
    localparam int OVR_CAP0 = 1;

    localparam int CODE_W   = 3;
    localparam int BASE_W   = 5;
    localparam int VEC_W    = BASE_W + CODE_W;

    localparam logic [CODE_W-1:0] CODE_CMP = 3'b110;
    localparam logic [CODE_W-1:0] CODE_CAP = 3'b100;
    localparam logic [CODE_W-1:0] CODE_OVF = 3'b000;

    typedef enum logic [1:0] {GRP_NONE, GRP_CMP, GRP_CAP, GRP_OVF} grp_e;

    // Maps an overrun slot to the source it watches.
    function automatic int ovr_src(input int k);
        return (k == OVR_CMP0) ? SRC_CMP0 : SRC_CAP0;
    endfunction
endpackage

// File: rtl/tmr_pend_flags.sv
// Pending and overrun flag bank. Each source latches its event strobe
// into a pending flag that software clears with a write-one-to-clear
// strobe; an event beats a clear in the same cycle. Two slots watch the
// DMA-capable sources and record a sticky overrun when a new event meets
// a flag that is still pending. Assumes strobes last one cycle.
module tmr_pend_flags
    import tmr_irq_pkg::*;
#(
    parameter int N_SRC = NSRC,
    parameter int N_OVR = NOVR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic [N_OVR-1:0] ovr_clr_i,
    output logic [N_SRC-1:0] pend_o,
    output logic [N_OVR-1:0] ovr_o
);
    logic [N_SRC-1:0] pend_q;
    logic [N_OVR-1:0] ovr_q;

    for (genvar i = 0; i < N_SRC; i++) begin : g_pend
        // Purpose: set on event, clear on strobe, event has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)          pend_q[i] <= 1'b0;
            else if (evt_i[i])   pend_q[i] <= 1'b1;
            else if (clr_i[i])   pend_q[i] <= 1'b0;
        end

        AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> pend_q[i]); // R1
    end

    for (genvar k = 0; k < N_OVR; k++) begin : g_ovr
        localparam int S = ovr_src(k);
        logic hit;
        // Purpose: detect a new event meeting an unserviced flag.
        always_comb hit = evt_i[S] & pend_q[S] & ~clr_i[S];

        // Purpose: sticky overrun, a new hit wins over its clear.
        always_ff @(posedge clk) begin
            if (!rst_n)            ovr_q[k] <= 1'b0;
            else if (hit)          ovr_q[k] <= 1'b1;
            else if (ovr_clr_i[k]) ovr_q[k] <= 1'b0;
        end

        AST_OVR_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovr_q[k]) |-> $past(evt_i[S] && pend_o[S])); // R8
        AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ovr_q[k] && !ovr_clr_i[k] |=> ovr_q[k]); // R9
    end

    assign pend_o = pend_q;
    assign ovr_o  = ovr_q;
endmodule

// File: rtl/tmr_vec_arb.sv
// Group arbiter and vector register. Reduces the enabled pending flags
// to three group hits, picks the group with the lowest fixed code and
// registers the request and the vector. The vector holds its value while
// no request is active. Assumes the source order of tmr_irq_pkg.
module tmr_vec_arb
    import tmr_irq_pkg::*;
#(
    parameter int N_SRC = NSRC,
    parameter int B_W   = BASE_W,
    parameter int C_W   = CODE_W,
    localparam int V_W  = B_W + C_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic             glb_en_i,
    input  logic [B_W-1:0]   base_i,
    output logic             irq_o,
    output logic [V_W-1:0]   vec_o
);
    logic [N_SRC-1:0] act;
    logic             any_act;
    grp_e             grp;
    logic [C_W-1:0]   code;
    logic             irq_q;
    logic [V_W-1:0]   vec_q;

    // Purpose: enabled pending sources and the winning group.
    always_comb begin
        act     = pend_i & en_i;
        any_act = |act;
        if (act[SRC_OVF])                    grp = GRP_OVF;
        else if (act[SRC_CAP0] | act[SRC_CAP1]) grp = GRP_CAP;
        else if (act[SRC_CMP0] | act[SRC_CMP1]) grp = GRP_CMP;
        else                                 grp = GRP_NONE;
    end

    // Purpose: translate the winning group into its fixed code.
    always_comb begin
        unique case (grp)
            GRP_OVF: code = CODE_OVF;
            GRP_CAP: code = CODE_CAP;
            GRP_CMP: code = CODE_CMP;
            default: code = CODE_OVF;
        endcase
    end

    // Purpose: register the request, and load the vector when it is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else begin
            irq_q <= glb_en_i & any_act;
            if (glb_en_i && any_act) vec_q <= {base_i, code};
        end
    end

    assign irq_o = irq_q;
    assign vec_o = vec_q;

    AST_IRQ_NEEDS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(glb_en_i)); // R3
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (vec_q[C_W-1:0] == CODE_OVF || vec_q[C_W-1:0] == CODE_CAP
                   || vec_q[C_W-1:0] == CODE_CMP)); // R5
    AST_OVF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        glb_en_i && pend_i[SRC_OVF] && en_i[SRC_OVF] |=> vec_q[C_W-1:0] == CODE_OVF); // R6
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en_i |=> $stable(vec_q)); // R10
endmodule

// File: rtl/tmr_irq_vec.sv
// Timer interrupt vector and overrun logic, top level. Ties the flag bank
// to the group arbiter. Assumes single-cycle event and clear strobes and
// a synchronous active-low reset.
module tmr_irq_vec
    import tmr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_i,
    input  logic [NSRC-1:0]   src_en_i,
    input  logic              glb_en_i,
    input  logic [BASE_W-1:0] vec_base_i,
    input  logic [NSRC-1:0]   pend_clr_i,
    input  logic [NOVR-1:0]   ovr_clr_i,
    output logic [NSRC-1:0]   pend_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic [NOVR-1:0]   ovr_o
);
    logic [NSRC-1:0] pend;

    tmr_pend_flags #(.N_SRC(NSRC), .N_OVR(NOVR)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .clr_i     (pend_clr_i),
        .ovr_clr_i (ovr_clr_i),
        .pend_o    (pend),
        .ovr_o     (ovr_o)
    );

    tmr_vec_arb #(.N_SRC(NSRC), .B_W(BASE_W), .C_W(CODE_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_i   (pend),
        .en_i     (src_en_i),
        .glb_en_i (glb_en_i),
        .base_i   (vec_base_i),
        .irq_o    (irq_o),
        .vec_o    (vec_o)
    );

    assign pend_o = pend;

    AST_MASKED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & src_en_i) == '0 |=> !irq_o); // R7
endmodule

// File: tb/sim_tmr_irq_vec.sv
// Bench: behavioural per-cycle reference model compared on every clock,
// plus directed scenario checks.
module sim_tmr_irq_vec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] evt = '0, en = 5'h1F, pclr = '0;
    logic       glb = 1'b1;
    logic [4:0] base = 5'h15;
    logic [1:0] oclr = '0;
    logic [4:0] pend;
    logic       irq;
    logic [7:0] vec;
    logic [1:0] ovr;

    int checks = 0, fails = 0;

    logic [4:0] m_pend = '0;
    logic [1:0] m_ovr = '0;
    logic       m_irq = 1'b0;
    logic [7:0] m_vec = '0;

    always #4 clk = ~clk;

    tmr_irq_vec u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .src_en_i(en), .glb_en_i(glb),
        .vec_base_i(base), .pend_clr_i(pclr), .ovr_clr_i(oclr),
        .pend_o(pend), .irq_o(irq), .vec_o(vec), .ovr_o(ovr)
    );

    function automatic int src_code(input int i);
        if (i == 4) return 0;
        if (i >= 2) return 4;
        return 6;
    endfunction

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        int best;
        if (!rst_n) begin
            m_pend <= '0; m_ovr <= '0; m_irq <= 1'b0; m_vec <= '0;
        end else begin
            for (int i = 0; i < 5; i++)
                if (evt[i]) m_pend[i] <= 1'b1;
                else if (pclr[i]) m_pend[i] <= 1'b0;
            for (int k = 0; k < 2; k++) begin
                int s;
                s = (k == 0) ? 0 : 2;
                if (evt[s] && m_pend[s] && !pclr[s]) m_ovr[k] <= 1'b1;
                else if (oclr[k]) m_ovr[k] <= 1'b0;
            end
            best = 8;
            for (int i = 0; i < 5; i++)
                if (m_pend[i] && en[i] && src_code(i) < best) best = src_code(i);
            m_irq <= glb && (best < 8);
            if (glb && best < 8) m_vec <= {base, 3'(best)};
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1/R2 pend", int'(pend), int'(m_pend));
        chk("R3 irq", int'(irq), int'(m_irq));
        chk("R4/R5/R6 vec", int'(vec), int'(m_vec));
        chk("R8/R9 ovr", int'(ovr), int'(m_ovr));
    endtask

    // One clock: inputs set before, strobes dropped after, compare at negedge.
    task automatic cyc(input logic [4:0] e, input logic [4:0] c, input logic [1:0] o);
        evt = e; pclr = c; oclr = o;
        @(negedge clk);
        compare_all();
        evt = '0; pclr = '0; oclr = '0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset", int'({pend, irq, vec, ovr}), 0);
        rst_n = 1'b1;
        cyc('0, '0, '0);

        // R1, R5: each source alone
        for (int i = 0; i < 5; i++) begin
            cyc(5'(1 << i), '0, '0);
            cyc('0, '0, '0);
            chk("R5 code", int'(vec[2:0]), src_code(i));
            chk("R4 base", int'(vec[7:3]), 'h15);
            cyc('0, 5'(1 << i), '0);
            cyc('0, '0, '0);
        end

        // R6: priority order as groups clear
        base = 5'h0A;
        cyc(5'b01010, '0, '0);
        cyc('0, '0, '0);
        chk("R6 cap over cmp", int'(vec[2:0]), 4);
        cyc(5'b10000, '0, '0);
        cyc('0, '0, '0);
        chk("R6 ovf first", int'(vec[2:0]), 0);
        cyc('0, 5'b10000, '0);
        cyc('0, '0, '0);
        chk("R6 back to cap", int'(vec[2:0]), 4);
        cyc('0, 5'b01000, '0);
        cyc('0, '0, '0);
        chk("R6 then cmp", int'(vec[2:0]), 6);

        // R7: masking
        cyc(5'b00100, '0, '0);
        en = 5'b11011;
        cyc('0, '0, '0);
        cyc('0, '0, '0);
        chk("R7 masked cap ignored", int'(vec[2:0]), 6);
        en = 5'b00000;
        cyc('0, '0, '0);
        cyc('0, '0, '0);
        chk("R7 all masked irq", int'(irq), 0);
        chk("R7 flags kept", int'(pend), 'b00110);
        en = 5'h1F;

        // R10: global disable holds vector
        glb = 1'b0; base = 5'h1F;
        cyc('0, '0, '0);
        cyc(5'b10000, '0, '0);
        cyc('0, '0, '0);
        chk("R10 irq off", int'(irq), 0);
        chk("R10 vec held", int'(vec), int'({5'h0A, 3'b110}));
        glb = 1'b1;
        cyc('0, 5'h1F, '0);
        cyc('0, '0, '0);

        // R8, R2: overrun and event-vs-clear races
        cyc(5'b00001, '0, '0);
        cyc(5'b00001, '0, '0);
        chk("R8 cmp0 overrun", int'(ovr), 'b01);
        cyc(5'b00100, '0, '0);
        cyc(5'b00100, 5'b00100, '0);
        chk("R2 event beats clear", int'(pend[2]), 1);
        chk("R8 no overrun on cleared", int'(ovr[1]), 0);
        cyc(5'b00010, '0, '0);
        cyc(5'b00010, '0, '0);
        chk("R8 cmp1 never overruns", int'(ovr), 'b01);

        // R9: sticky, hit beats clear
        cyc('0, '0, '0);
        chk("R9 sticky", int'(ovr[0]), 1);
        cyc(5'b00001, '0, 2'b01);
        chk("R9 hit beats clear", int'(ovr[0]), 1);
        cyc('0, '0, 2'b01);
        chk("R9 clear", int'(ovr[0]), 0);

        // R11: reset mid-run
        rst_n = 1'b0;
        cyc('0, '0, '0);
        chk("R11 reset again", int'({pend, irq, vec, ovr}), 0);
        rst_n = 1'b1;
        cyc('0, '0, '0);
        report();
    end
endmodule